// File: doc/BRIEF.md
# Seconds Watchdog Logical Device

This block is a watchdog timer that software sees as a few byte-wide configuration registers inside one logical device. A countdown register holds the time left in seconds. Writing a nonzero value into it arms the timer, or re-arms it if it is already running. Writing zero disarms it. Reading the register returns the seconds that remain. A clock prescaler divides the system clock into one-second ticks. When the count runs out, the block drives its watchdog output high for a fixed number of cycles and records the event in a status register.

The countdown advances only while the logical device's activate bit is set. While that bit is clear, the count and the prescaler are frozen and the output is held low. A parameter selects one of two register layouts: the countdown and control registers move between the two layouts, and the status register stays at the same index in both.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, the countdown, control, status and activate registers all read 0x00 and `wdt_out` is low.
- R2: With the default layout, the countdown register is at index 0xF6. A nonzero write loads the count and restarts the prescaler. The count then drops by one every TICK_CYCLES clock cycles while activated, and a read returns the live count.
- R3: A nonzero write while the count is running reloads it and restarts the prescaler. If the write falls in the same cycle as a tick, the written value wins.
- R4: Writing 0x00 to the countdown register stops the timer. No expiry follows and the count stays 0.
- R5: When the count steps from 1 to 0, `wdt_out` goes high from the next cycle for exactly PULSE_CYCLES cycles, and the count then holds at 0.
- R6: The status register is at index 0xF7. Bit 4 is set by an expiry, cleared by writing 0 to bit 4, and left unchanged by writing 1 to it. Bits 7 and 6 are read/write storage. The other bits read 0.
- R7: The activate register is at index 0x30, bit 0. While it is 0, the count and the prescaler hold their values and `wdt_out` is low from the cycle after the bit is cleared.
- R8: The control register is at index 0xF5 in the default layout. All 8 bits are read/write storage.
- R9: With ALT_MAP=1, the countdown register is at index 0xF4 and control is at 0xF3. Reads of any unmapped index return 0x00, and writes to an unmapped index have no effect.
- R10: The full 8-bit range is accepted. A load of 255 reads back 255 and reads 254 one tick later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wdt_out | output | 1 | Watchdog expiry pulse |

## Verification
All register state updates on the clock edge that takes the write, and reads are combinational. A written value is therefore visible at the falling edge that follows that write edge. The first decrement lands TICK_CYCLES edges after the write edge, and each later decrement lands TICK_CYCLES edges after the one before. The 1-to-0 edge also sets status bit 4 and starts the output pulse, so `wdt_out` is high at the next PULSE_CYCLES falling edges. The bench drives every input at a falling edge and counts falling edges from the write. It derives each expected count from that distance as N minus the distance divided by TICK_CYCLES, floored at zero. It sweeps every load from 1 to 6 cycle by cycle through expiry, and it samples the activate, keep-alive and stop cases on the same count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW = 8;
  localparam logic [7:0] IDX_ACTIVATE  = 8'h30;
  localparam logic [7:0] IDX_STATUS    = 8'hF7;
  localparam logic [7:0] IDX_TMO_STD   = 8'hF6;
  localparam logic [7:0] IDX_CTL_STD   = 8'hF5;
  localparam logic [7:0] IDX_TMO_ALT   = 8'hF4;
  localparam logic [7:0] IDX_CTL_ALT   = 8'hF3;
  localparam int unsigned STS_EVT_BIT  = 4;

  typedef struct packed {
    logic [1:0] keep;
    logic       evt;
  } wdt_status_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] div_q, div_d;
  logic          at_last;

  assign at_last = (div_q == LAST);
  assign tick_o  = en_i & at_last;

  always_comb begin
    div_d = div_q;
    if (restart_i)   div_d = '0;
    else if (en_i)   div_d = at_last ? '0 : div_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST);
  p_div_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !restart_i) |=> $stable(div_q));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          live_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step;

  assign live_o   = (cnt_q != '0);
  assign step     = run_i & tick_i & live_o & ~load_i;
  assign expire_o = step & (cnt_q == CW'(1));
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)    cnt_d = load_val_i;
    else if (step) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cnt_q <= $past(cnt_q)));
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o
);
  localparam int unsigned LW = $clog2(PULSE_CYCLES + 1);

  logic [LW-1:0] left_q, left_d;

  assign busy_o = (left_q != '0);

  always_comb begin
    left_d = left_q;
    if (fire_i)      left_d = LW'(PULSE_CYCLES);
    else if (busy_o) left_d = left_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> busy_o);
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= LW'(PULSE_CYCLES));
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_CYCLES  = 125_000_000,
  parameter int unsigned PULSE_CYCLES = 16,
  parameter bit          ALT_MAP      = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          wdt_out
);
  localparam logic [7:0] IDX_TMO = ALT_MAP ? IDX_TMO_ALT : IDX_TMO_STD;
  localparam logic [7:0] IDX_CTL = ALT_MAP ? IDX_CTL_ALT : IDX_CTL_STD;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic          act_q, act_d;
  logic [DW-1:0] ctl_q, ctl_d;
  wdt_status_t   sts_q, sts_d;

  logic          wr_tmo, wr_ctl, wr_sts, wr_act;
  logic          tick, live, expire, pulse;
  logic [DW-1:0] cnt;

  assign wr_tmo = reg_wr & (reg_addr == IDX_TMO);
  assign wr_ctl = reg_wr & (reg_addr == IDX_CTL);
  assign wr_sts = reg_wr & (reg_addr == IDX_STATUS);
  assign wr_act = reg_wr & (reg_addr == IDX_ACTIVATE);

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk       (clk),
    .rst_n     (rst_ni),
    .en_i      (act_q & live),
    .restart_i (wr_tmo),
    .tick_o    (tick)
  );

  wdt_countdown #(.CW(DW)) u_count (
    .clk        (clk),
    .rst_n      (rst_ni),
    .run_i      (act_q),
    .tick_i     (tick),
    .load_i     (wr_tmo),
    .load_val_i (reg_wdata),
    .cnt_o      (cnt),
    .live_o     (live),
    .expire_o   (expire)
  );

  wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_ni),
    .fire_i (expire),
    .busy_o (pulse)
  );

  assign wdt_out = pulse & act_q;

  always_comb begin
    act_d = act_q;
    ctl_d = ctl_q;
    sts_d = sts_q;
    if (wr_act) act_d = reg_wdata[0];
    if (wr_ctl) ctl_d = reg_wdata;
    if (wr_sts) begin
      sts_d.keep = reg_wdata[7:6];
      if (!reg_wdata[STS_EVT_BIT]) sts_d.evt = 1'b0;
    end
    if (expire) sts_d.evt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      act_q <= act_d;
      ctl_q <= ctl_d;
      sts_q <= sts_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IDX_TMO:      reg_rdata = cnt;
      IDX_CTL:      reg_rdata = ctl_q;
      IDX_STATUS:   reg_rdata = {sts_q.keep, 1'b0, sts_q.evt, 4'b0000};
      IDX_ACTIVATE: reg_rdata = {7'd0, act_q};
      default:      reg_rdata = '0;
    endcase
  end

  p_out_gated_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    wdt_out |-> act_q);
  p_evt_set_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    expire |=> sts_q.evt);
  p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (sts_q.evt && !wr_sts) |=> sts_q.evt);
endmodule

// File: tb/sec_watchdog_test.sv
module sec_watchdog_test;
  localparam int T = 4;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'hF6;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] rdata, rdata_alt;
  logic       wout, wout_alt;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sec_watchdog #(.TICK_CYCLES(T), .PULSE_CYCLES(P), .ALT_MAP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .wdt_out(wout));

  sec_watchdog #(.TICK_CYCLES(T), .PULSE_CYCLES(P), .ALT_MAP(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_alt), .wdt_out(wout_alt));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // entered at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'hF6;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a; #1; v = int'(rdata); reg_addr = 8'hF6; #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_cnt(input int n, input int m);
    return (m >= n * T) ? 0 : n - m / T;
  endfunction

  task automatic run_all();
    int v;
    wait_n(5); rst_n = 1'b1; wait_n(4);
    // R1 reset state
    rd(8'hF6, v); chk("R1 timeout", v, 0);
    rd(8'hF5, v); chk("R1 control", v, 0);
    rd(8'hF7, v); chk("R1 status", v, 0);
    rd(8'h30, v); chk("R1 activate", v, 0);
    chk("R1 out", int'(wout), 0);

    // R8 control storage
    wr(8'hF5, 8'hA5); rd(8'hF5, v); chk("R8 control", v, 165);

    // R7 frozen while inactive
    wr(8'hF6, 8'd2); wait_n(5 * T);
    chk("R7 frozen count", int'(rdata), 2);
    chk("R7 out low", int'(wout), 0);
    wr(8'h30, 8'h01);
    wait_n(T - 1); chk("R7 after activate", int'(rdata), 2);
    wait_n(1);     chk("R7 first tick", int'(rdata), 1);
    wait_n(T);     chk("R5 expire count", int'(rdata), 0);
    chk("R5 expire out", int'(wout), 1);
    wait_n(P + 1);
    wr(8'hF7, 8'h00);

    // R2/R5/R6 sweep of loads 1..6
    for (int n = 1; n <= 6; n++) begin
      wr(8'hF6, 8'(n));
      for (int m = 0; m <= n * T + P + 1; m++) begin
        chk("R2 count", int'(rdata), exp_cnt(n, m));
        chk("R5 pulse", int'(wout), (m >= n * T && m < n * T + P) ? 1 : 0);
        @(negedge clk);
      end
      rd(8'hF7, v); chk("R6 event set", v, 16);
      wr(8'hF7, 8'hFF); rd(8'hF7, v); chk("R6 write one keeps", v, 208);
      wr(8'hF7, 8'h00); rd(8'hF7, v); chk("R6 write zero clears", v, 0);
    end

    // R6 writing 1 to bit 4 does not set it
    wr(8'hF7, 8'hFF); rd(8'hF7, v); chk("R6 no set by write", v, 192);
    wr(8'hF7, 8'h00);

    // R3 keep-alive reload, including a write on a tick cycle
    wr(8'hF6, 8'd3); wait_n(2 * T + 1);
    chk("R3 before reload", int'(rdata), 1);
    wr(8'hF6, 8'd3);
    wait_n(T - 1); chk("R3 reload held", int'(rdata), 3);
    wr(8'hF6, 8'd4);
    chk("R3 write beats tick", int'(rdata), 4);
    wait_n(T - 1); chk("R3 after tick write", int'(rdata), 4);
    wait_n(1);     chk("R3 next tick", int'(rdata), 3);

    // R4 stop
    wr(8'hF6, 8'd0); wait_n(10 * T);
    chk("R4 stopped count", int'(rdata), 0);
    chk("R4 no pulse", int'(wout), 0);
    rd(8'hF7, v); chk("R4 no event", v, 0);

    // R10 full range
    wr(8'hF6, 8'd255); chk("R10 load", int'(rdata), 255);
    wait_n(T); chk("R10 tick", int'(rdata), 254);

    // R7 clearing activate during pulse
    wr(8'hF6, 8'd1); wait_n(T - 1);
    chk("R7 pre-expiry out", int'(wout), 0);
    wait_n(1); chk("R7 pulse", int'(wout), 1);
    wr(8'h30, 8'h00); chk("R7 gated", int'(wout), 0);
    wr(8'h30, 8'h01); wait_n(P + 2);
    wr(8'hF7, 8'h00);

    // R9 alternate layout and unmapped indices
    wr(8'hF4, 8'd9);
    reg_addr = 8'hF4; #1;
    chk("R9 alt timeout", int'(rdata_alt), 9);
    chk("R9 std unmapped", int'(rdata), 0);
    reg_addr = 8'hF6; #1;
    chk("R9 alt unmapped", int'(rdata_alt), 0);
    @(negedge clk);
    wr(8'hF3, 8'h5A);
    reg_addr = 8'hF3; #1; chk("R9 alt control", int'(rdata_alt), 90);
    reg_addr = 8'hF5; #1; chk("R9 std control kept", int'(rdata), 165);
    reg_addr = 8'h10; #1; chk("R9 unmapped", int'(rdata), 0);
    reg_addr = 8'hF6;
    @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule